// File: doc/BRIEF.md
# Two-Level Self-Repairing Word Memory

This block wraps a word-oriented memory of 4096 four-bit words. The memory is built as four 1024-word sub-blocks and one extra 1024-word sub-block held in reserve. Every sub-block, including the reserve, carries two spare words. After reset, or when `start` is pulsed, the block runs a March C- test on each sub-block in turn, spare words included, with no outside help. It records which words failed.

Repair works at two levels. If a sub-block has no more faulty words than it has good spare words, each faulty word is steered to a spare word in that same sub-block. If a sub-block has too many faults, its whole address range is steered to the reserve sub-block. Once the test finishes, user reads and writes go through this steering logic, and reads keep a one-cycle latency.

The storage arrays are behavioural. Each array has a small table of stuck-word entries that model manufacturing defects. These entries are programmed through the `dfx_*` pins.

Top module: `hier_repair_mem`

## Requirements
- R1: From reset the block is busy (`busy`=1, `done`=0) and tests every sub-block without any request. When it finishes, `done`=1 and `busy`=0.
- R2: With no defects, every logical address returns the last value written to it, and `repair_fail` stays 0.
- R3: A sub-block with one or two defective words returns correct data at all its addresses, because those words are moved to its own spare words. `repair_fail` stays 0.
- R4: A sub-block with three defective words has its whole range steered to the reserve sub-block (region index 4). All its addresses return correct data and `repair_fail` stays 0.
- R5: A defective spare word (array index at or above the sub-block word count) is never used. A single faulty word in that sub-block is served by the remaining good spare.
- R6: When two sub-blocks overflow, `repair_fail` goes to 1. The lowest-numbered overflowing sub-block is still served correctly through the reserve.
- R7: A reserve sub-block with three defective words sets `repair_fail` to 1.
- R8: `repair_fail` is 0 after reset. Once set, it stays 1 until reset, even across later tests that find no defects.
- R9: Requests made while `busy`=1 have no effect: no `rd_valid`, and writes are lost. Every word reads 0000 after a test.
- R10: A read accepted at one clock edge gives `rd_valid`=1 and its data right after the next edge, for plain, locally remapped and reserve-steered addresses alike. `rd_valid` is 0 one cycle later.
- R11: A `start` pulse while `done`=1 starts a new test: `busy` is 1 and `done` is 0 after the next edge.
- R12: The top two address bits select the sub-block and the low ten bits select the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears defect entries and starts the power-up test |
| start | input | 1 | Pulse while idle to re-run test and repair |
| busy | output | 1 | Test and repair in progress |
| done | output | 1 | Test finished, user traffic accepted |
| repair_fail | output | 1 | Sticky flag: some addresses could not be repaired |
| req_en | input | 1 | User access request |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Logical word address |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 4 | Read data |
| dfx_wr | input | 1 | Program one defect-model entry |
| dfx_region | input | 3 | Array index 0-3 sub-blocks, 4 reserve |
| dfx_slot | input | 2 | Defect entry number in that array |
| dfx_on | input | 1 | Entry active |
| dfx_idx | input | 11 | Array word index; values at or above 1024 are spare words |
| dfx_val | input | 4 | Value the stuck word always reads |

## Verification
The bench writes an address-dependent pattern over the whole logical space and reads it back. It does this under several defect layouts, and each layout separates one repair path from the others.

- **Clean memory:** proves the plain address split.
- **Two stuck words in one sub-block:** only passes if local spare steering works.
- **Bad spare plus one bad word:** shows whether the controller skips a failed spare.
- **Three stuck words:** forces whole-range steering to the reserve.
- **Two overflowing sub-blocks, then a clean re-run:** separates a sticky failure flag from one that is recomputed.
- **Broken reserve:** covers the remaining failure cause.

Requests during the test check that nothing lands while busy.

// File: rtl/hrm_pkg.sv
package hrm_pkg;

    typedef enum logic [1:0] {
        CTL_LAUNCH,
        CTL_TEST,
        CTL_DONE
    } ctl_state_e;

    // One march element: optional read of a background, optional write, direction
    typedef struct packed {
        logic has_rd;
        logic rd_bit;
        logic has_wr;
        logic wr_bit;
        logic down;
    } march_elem_t;

    localparam int MARCH_LEN = 6;

    // March C-: up(w0) up(r0,w1) up(r1,w0) down(r0,w1) down(r1,w0) up(r0)
    function automatic march_elem_t march_elem(input logic [2:0] e);
        march_elem_t m;
        case (e)
            3'd0:    m = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            3'd1:    m = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            3'd2:    m = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
            3'd3:    m = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            3'd4:    m = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
            default: m = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hrm_region_array.sv
module hrm_region_array #(
    parameter int DATA_W = 4,
    parameter int NWS    = 1026,
    parameter int NDEF   = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       re,
    input  logic                       we,
    input  logic [$clog2(NWS)-1:0]     idx,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       dfx_wr,
    input  logic [$clog2(NDEF)-1:0]    dfx_slot,
    input  logic                       dfx_on,
    input  logic [$clog2(NWS)-1:0]     dfx_idx,
    input  logic [DATA_W-1:0]          dfx_val
);
    localparam int IDX_W = $clog2(NWS);

    logic [DATA_W-1:0] mem   [NWS];
    logic [NDEF-1:0]   d_on;
    logic [IDX_W-1:0]  d_idx [NDEF];
    logic [DATA_W-1:0] d_val [NDEF];
    logic              stuck;
    logic [DATA_W-1:0] stuck_val;

    always_comb begin
        stuck     = 1'b0;
        stuck_val = '0;
        for (int k = 0; k < NDEF; k++) begin
            if (d_on[k] && d_idx[k] == idx) begin
                stuck     = 1'b1;
                stuck_val = d_val[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we && int'(idx) < NWS) mem[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (dfx_wr) begin
            d_idx[dfx_slot] <= dfx_idx;
            d_val[dfx_slot] <= dfx_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            d_on  <= '0;
        end else begin
            if (re) rdata <= stuck ? stuck_val : mem[idx];
            if (dfx_wr) d_on[dfx_slot] <= dfx_on;
        end
    end

endmodule

// File: rtl/hrm_march_engine.sv
module hrm_march_engine
    import hrm_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int NWS    = 1026
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   go,
    input  logic [DATA_W-1:0]      rdata,
    output logic                   op_re,
    output logic                   op_we,
    output logic [$clog2(NWS)-1:0] op_idx,
    output logic [DATA_W-1:0]      op_wdata,
    output logic                   flt,
    output logic [$clog2(NWS)-1:0] flt_idx,
    output logic                   fin
);
    localparam int               IDX_W = $clog2(NWS);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NWS - 1);

    logic              active, ending, phase, rd_pend, rd_exp;
    logic [2:0]        elem;
    logic [IDX_W-1:0]  idx, rd_idx;
    march_elem_t       cur, nxt;
    logic              do_read, at_end;

    always_comb begin
        cur      = march_elem(elem);
        nxt      = march_elem(elem + 3'd1);
        do_read  = active && cur.has_rd && !phase;
        op_re    = do_read;
        op_we    = active && !do_read && cur.has_wr;
        op_idx   = idx;
        op_wdata = {DATA_W{cur.wr_bit}};
        at_end   = cur.down ? (idx == '0) : (idx == LAST);
        flt      = rd_pend && (rdata != {DATA_W{rd_exp}});
        flt_idx  = rd_idx;
        fin      = ending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            ending  <= 1'b0;
            phase   <= 1'b0;
            elem    <= '0;
            idx     <= '0;
            rd_pend <= 1'b0;
            rd_idx  <= '0;
            rd_exp  <= 1'b0;
        end else begin
            rd_pend <= do_read;
            rd_idx  <= idx;
            rd_exp  <= cur.rd_bit;
            ending  <= 1'b0;
            if (go) begin
                active <= 1'b1;
                elem   <= '0;
                idx    <= '0;
                phase  <= 1'b0;
            end else if (active) begin
                if (do_read && cur.has_wr) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (at_end) begin
                        if (int'(elem) == MARCH_LEN - 1) begin
                            active <= 1'b0;
                            ending <= 1'b1;
                        end else begin
                            elem <= elem + 3'd1;
                            idx  <= nxt.down ? LAST : '0;
                        end
                    end else begin
                        idx <= cur.down ? idx - 1'b1 : idx + 1'b1;
                    end
                end
            end
        end
    end

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> idx <= LAST);

    // R1
    fin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ending |-> !active && !op_re && !op_we);

endmodule

// File: rtl/hrm_fault_log.sv
module hrm_fault_log #(
    parameter int WORD_W = 10,
    parameter int NSPARE = 2
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   clr,
    input  logic                                   log_en,
    input  logic [$clog2((1<<WORD_W)+NSPARE)-1:0]  log_idx,
    input  logic [WORD_W-1:0]                      look_word,
    output logic                                   look_hit,
    output logic [$clog2((1<<WORD_W)+NSPARE)-1:0]  look_idx,
    output logic                                   unusable
);
    localparam int NW    = 1 << WORD_W;
    localparam int IDX_W = $clog2(NW + NSPARE);

    logic [NSPARE-1:0] ent_vld, spare_bad;
    logic [WORD_W-1:0] ent_word [NSPARE];
    logic              ovf;

    logic              is_spare, dup, have_free;
    int                free_k, n_used, n_good, rank;

    always_comb begin
        is_spare  = int'(log_idx) >= NW;
        dup       = 1'b0;
        have_free = 1'b0;
        free_k    = 0;
        n_used    = 0;
        n_good    = 0;
        for (int k = NSPARE - 1; k >= 0; k--) begin
            if (ent_vld[k] && ent_word[k] == log_idx[WORD_W-1:0]) dup = 1'b1;
            if (!ent_vld[k]) begin
                have_free = 1'b1;
                free_k    = k;
            end
            if (ent_vld[k]) n_used++;
            if (!spare_bad[k]) n_good++;
        end
        unusable = ovf || (n_used > n_good);
    end

    // Entry k is served by the k-th spare that passed the test
    always_comb begin
        look_hit = 1'b0;
        look_idx = IDX_W'(look_word);
        rank     = 0;
        for (int k = 0; k < NSPARE; k++) begin
            if (ent_vld[k] && ent_word[k] == look_word) begin
                rank = 0;
                for (int s = 0; s < NSPARE; s++) begin
                    if (!spare_bad[s]) begin
                        if (rank == k) begin
                            look_hit = 1'b1;
                            look_idx = IDX_W'(NW + s);
                        end
                        rank++;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ent_vld   <= '0;
            spare_bad <= '0;
            ovf       <= 1'b0;
        end else if (log_en) begin
            if (is_spare) begin
                for (int s = 0; s < NSPARE; s++)
                    if (int'(log_idx) == NW + s) spare_bad[s] <= 1'b1;
            end else if (!dup) begin
                if (have_free) ent_vld[free_k] <= 1'b1;
                else           ovf             <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (log_en && !is_spare && !dup && have_free)
            ent_word[free_k] <= log_idx[WORD_W-1:0];
    end

    // R3
    log_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (ent_vld & $past(ent_vld)) == $past(ent_vld));

    // R4
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovf && !clr |=> unusable);

endmodule

// File: rtl/hier_repair_mem.sv
module hier_repair_mem
    import hrm_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int BLK_W  = 2,
    parameter int WORD_W = 10,
    parameter int NSPARE = 2,
    parameter int NDEF   = 4
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   repair_fail,
    input  logic                                   req_en,
    input  logic                                   req_we,
    input  logic [BLK_W+WORD_W-1:0]                req_addr,
    input  logic [DATA_W-1:0]                      req_wdata,
    output logic                                   rd_valid,
    output logic [DATA_W-1:0]                      rd_data,
    input  logic                                   dfx_wr,
    input  logic [$clog2((1<<BLK_W)+1)-1:0]        dfx_region,
    input  logic [$clog2(NDEF)-1:0]                dfx_slot,
    input  logic                                   dfx_on,
    input  logic [$clog2((1<<WORD_W)+NSPARE)-1:0]  dfx_idx,
    input  logic [DATA_W-1:0]                      dfx_val
);
    localparam int ADDR_W = BLK_W + WORD_W;
    localparam int NBLK   = 1 << BLK_W;
    localparam int NREG   = NBLK + 1;
    localparam int NWS    = (1 << WORD_W) + NSPARE;
    localparam int IDX_W  = $clog2(NWS);
    localparam int REG_W  = $clog2(NREG);
    localparam logic [REG_W-1:0] SPARE_REG = REG_W'(NBLK);

    ctl_state_e        st;
    logic [REG_W-1:0]  cur_reg, tgt, tgt_q;
    logic              fail_q, fail_cond, go, clr_logs, acc;
    logic              eng_re, eng_we, eng_flt, eng_fin;
    logic [IDX_W-1:0]  eng_idx, eng_flt_idx, phys_idx;
    logic [DATA_W-1:0] eng_wdata, eng_rdata;
    logic [DATA_W-1:0] arr_rdata [NREG];
    logic [IDX_W-1:0]  lg_idx    [NREG];
    logic [NREG-1:0]   lg_hit, lg_unus;
    logic              swap_en;
    logic [BLK_W-1:0]  swap_blk, blk;
    logic [WORD_W-1:0] word;
    int                n_bad;

    assign go          = (st == CTL_LAUNCH);
    assign busy        = (st != CTL_DONE);
    assign done        = (st == CTL_DONE);
    assign clr_logs    = done && start;
    assign repair_fail = fail_q;
    assign acc         = req_en && !busy;
    assign blk         = req_addr[ADDR_W-1:WORD_W];
    assign word        = req_addr[WORD_W-1:0];
    assign eng_rdata   = arr_rdata[cur_reg];
    assign rd_data     = arr_rdata[tgt_q];

    // Whole-block steering: lowest overflowing sub-block takes the reserve
    always_comb begin
        swap_en  = 1'b0;
        swap_blk = '0;
        n_bad    = 0;
        for (int b = NBLK - 1; b >= 0; b--) begin
            if (lg_unus[b]) begin
                n_bad++;
                if (!lg_unus[NBLK]) begin
                    swap_en  = 1'b1;
                    swap_blk = BLK_W'(b);
                end
            end
        end
        fail_cond = (n_bad > 1) || lg_unus[NBLK];
        tgt       = (swap_en && blk == swap_blk) ? SPARE_REG : REG_W'(blk);
        phys_idx  = lg_hit[tgt] ? lg_idx[tgt] : IDX_W'(word);
    end

    hrm_march_engine #(.DATA_W(DATA_W), .NWS(NWS)) engine_i (
        .clk(clk), .rst(rst), .go(go), .rdata(eng_rdata),
        .op_re(eng_re), .op_we(eng_we), .op_idx(eng_idx), .op_wdata(eng_wdata),
        .flt(eng_flt), .flt_idx(eng_flt_idx), .fin(eng_fin)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_region
        logic rsel_t, rsel_u;
        assign rsel_t = (cur_reg == REG_W'(r));
        assign rsel_u = (tgt == REG_W'(r));

        hrm_region_array #(.DATA_W(DATA_W), .NWS(NWS), .NDEF(NDEF)) array_i (
            .clk(clk), .rst(rst),
            .re(busy ? (eng_re && rsel_t) : (acc && !req_we && rsel_u)),
            .we(busy ? (eng_we && rsel_t) : (acc && req_we && rsel_u)),
            .idx(busy ? eng_idx : phys_idx),
            .wdata(busy ? eng_wdata : req_wdata),
            .rdata(arr_rdata[r]),
            .dfx_wr(dfx_wr && dfx_region == REG_W'(r)),
            .dfx_slot(dfx_slot), .dfx_on(dfx_on), .dfx_idx(dfx_idx), .dfx_val(dfx_val)
        );

        hrm_fault_log #(.WORD_W(WORD_W), .NSPARE(NSPARE)) log_i (
            .clk(clk), .rst(rst), .clr(clr_logs),
            .log_en(eng_flt && rsel_t), .log_idx(eng_flt_idx),
            .look_word(word), .look_hit(lg_hit[r]), .look_idx(lg_idx[r]),
            .unusable(lg_unus[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= CTL_LAUNCH;
            cur_reg  <= '0;
            fail_q   <= 1'b0;
            rd_valid <= 1'b0;
            tgt_q    <= '0;
        end else begin
            rd_valid <= acc && !req_we;
            if (acc) tgt_q <= tgt;
            case (st)
                CTL_LAUNCH: st <= CTL_TEST;
                CTL_TEST: if (eng_fin) begin
                    if (cur_reg == SPARE_REG) st <= CTL_DONE;
                    else begin
                        cur_reg <= cur_reg + 1'b1;
                        st      <= CTL_LAUNCH;
                    end
                end
                default: begin
                    fail_q <= fail_q || fail_cond;
                    if (start) begin
                        cur_reg <= '0;
                        st      <= CTL_LAUNCH;
                    end
                end
            endcase
        end
    end

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(busy));

    // R8
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        repair_fail |=> repair_fail);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        done && start |=> busy && !done);

    // R1
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done);

endmodule

// File: tb/hier_repair_mem_tb_top.sv
module hier_repair_mem_tb_top;
    localparam int DATA_W = 4;
    localparam int BLK_W  = 2;
    localparam int WORD_W = 4;
    localparam int NSPARE = 2;
    localparam int NDEF   = 4;
    localparam int NW     = 1 << WORD_W;
    localparam int NLOG   = (1 << BLK_W) * NW;
    localparam int IDX_W  = $clog2(NW + NSPARE);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, repair_fail, rd_valid;
    logic req_en = 1'b0, req_we = 1'b0;
    logic [BLK_W+WORD_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0, rd_data;
    logic dfx_wr = 1'b0, dfx_on = 1'b0;
    logic [2:0] dfx_region = '0;
    logic [1:0] dfx_slot = '0;
    logic [IDX_W-1:0] dfx_idx = '0;
    logic [DATA_W-1:0] dfx_val = '0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    hier_repair_mem #(.DATA_W(DATA_W), .BLK_W(BLK_W), .WORD_W(WORD_W),
                      .NSPARE(NSPARE), .NDEF(NDEF)) dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .repair_fail(repair_fail), .req_en(req_en), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .dfx_wr(dfx_wr), .dfx_region(dfx_region),
        .dfx_slot(dfx_slot), .dfx_on(dfx_on), .dfx_idx(dfx_idx), .dfx_val(dfx_val)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(input int a, input int seed);
        return 4'((a * 5 + seed) ^ (a >> 2));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done && !busy, tag, {busy, done}, 1);
        @(negedge clk);
    endtask

    task automatic run_test(input string tag);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(tag);
    endtask

    task automatic do_write(input int a, input logic [3:0] d);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b1; req_addr = 6'(a); req_wdata = d;
        @(negedge clk);
        req_en = 1'b0; req_we = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [3:0] d, output logic v);
        @(negedge clk);
        req_en = 1'b1; req_we = 1'b0; req_addr = 6'(a);
        @(negedge clk);
        req_en = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    task automatic set_defect(input int r, input int s, input bit on, input int i, input logic [3:0] v);
        @(negedge clk);
        dfx_wr = 1'b1; dfx_region = 3'(r); dfx_slot = 2'(s);
        dfx_on = on; dfx_idx = IDX_W'(i); dfx_val = v;
        @(negedge clk);
        dfx_wr = 1'b0;
    endtask

    task automatic clear_defects();
        for (int r = 0; r < 5; r++)
            for (int s = 0; s < NDEF; s++)
                set_defect(r, s, 1'b0, 0, 4'h0);
    endtask

    task automatic verify_range(input string tag, input int lo, input int hi, input int seed);
        logic [3:0] d;
        logic v;
        for (int a = lo; a < hi; a++) do_write(a, pat(a, seed));
        for (int a = lo; a < hi; a++) begin
            do_read(a, d, v);
            chk(v && d == pat(a, seed), tag, {v, d}, {1'b1, pat(a, seed)});
        end
    endtask

    task automatic t_power_up();
        chk(busy == 1'b1 && done == 1'b0, "R1 busy after reset", {busy, done}, 2);
        chk(repair_fail == 1'b0, "R8 flag clear after reset", repair_fail, 0);
        wait_done("R1 power-up test completes");
    endtask

    task automatic t_clean();
        verify_range("R2 R12 clean memory", 0, NLOG, 3);
        chk(repair_fail == 1'b0, "R2 no failure", repair_fail, 0);
    endtask

    task automatic t_latency(input int a, input string tag);
        logic [3:0] d;
        logic v;
        do_write(a, 4'hC);
        do_read(a, d, v);
        chk(v && d == 4'hC, tag, {v, d}, {1'b1, 4'hC});
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 valid single cycle", rd_valid, 0);
    endtask

    task automatic t_busy_ignore();
        logic [3:0] d;
        logic v;
        do_write(3, 4'hA);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, "R11 restart raises busy", {busy, done}, 2);
        repeat (4) @(negedge clk);
        do_write(3, 4'h9);
        do_read(3, d, v);
        chk(v == 1'b0, "R9 no read while busy", v, 0);
        wait_done("R11 rerun completes");
        do_read(3, d, v);
        chk(v && d == 4'h0, "R9 write while busy lost", {v, d}, {1'b1, 4'h0});
    endtask

    task automatic t_local();
        set_defect(1, 0, 1'b1, 2, 4'h5);
        set_defect(1, 1, 1'b1, 9, 4'h5);
        run_test("R3 test with local faults");
        verify_range("R3 local spare repair", 0, NLOG, 7);
        chk(repair_fail == 1'b0, "R3 no failure", repair_fail, 0);
        t_latency(NW + 2, "R10 remapped read latency");
    endtask

    task automatic t_spare_bad();
        clear_defects();
        set_defect(2, 0, 1'b1, NW, 4'h5);
        set_defect(2, 1, 1'b1, 5, 4'h5);
        run_test("R5 test with bad spare");
        verify_range("R5 skip bad spare", 2 * NW, 3 * NW, 11);
        chk(repair_fail == 1'b0, "R5 no failure", repair_fail, 0);
    endtask

    task automatic t_swap();
        clear_defects();
        set_defect(0, 0, 1'b1, 1, 4'h5);
        set_defect(0, 1, 1'b1, 4, 4'h5);
        set_defect(0, 2, 1'b1, 7, 4'h5);
        run_test("R4 test with overflow");
        verify_range("R4 block steered to reserve", 0, NLOG, 13);
        chk(repair_fail == 1'b0, "R4 no failure", repair_fail, 0);
        t_latency(4, "R10 steered read latency");
    endtask

    task automatic t_double_fail();
        set_defect(3, 0, 1'b1, 0, 4'h5);
        set_defect(3, 1, 1'b1, 1, 4'h5);
        set_defect(3, 2, 1'b1, 2, 4'h5);
        run_test("R6 test with two overflows");
        chk(repair_fail == 1'b1, "R6 failure raised", repair_fail, 1);
        verify_range("R6 lowest block still served", 0, NW, 2);
    endtask

    task automatic t_sticky();
        clear_defects();
        run_test("R8 clean rerun");
        chk(repair_fail == 1'b1, "R8 flag sticky", repair_fail, 1);
        verify_range("R8 memory usable after rerun", 0, NLOG, 5);
    endtask

    task automatic t_reserve_fail();
        do_reset();
        chk(busy == 1'b1 && done == 1'b0, "R1 busy after second reset", {busy, done}, 2);
        chk(repair_fail == 1'b0, "R8 reset clears flag", repair_fail, 0);
        wait_done("R1 second power-up test");
        set_defect(4, 0, 1'b1, 3, 4'h5);
        set_defect(4, 1, 1'b1, 6, 4'h5);
        set_defect(4, 2, 1'b1, 8, 4'h5);
        run_test("R7 test with broken reserve");
        chk(repair_fail == 1'b1, "R7 reserve failure", repair_fail, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL R1 watchdog: actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        t_power_up();
        t_clean();
        t_latency(40, "R10 plain read latency");
        t_busy_ignore();
        t_local();
        t_spare_bad();
        t_swap();
        t_double_fail();
        t_sticky();
        t_reserve_fail();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule